// File: doc/BRIEF.md
# TDM Frame Deserializer with Holding Register

This block is the receive end of a time-division multiplexed serial link. One bit of a repeating frame arrives on every clock. A frame holds a fixed number of timeslots, and each timeslot carries one byte. The transmitter marks the first bit of each frame with a sync pulse. The block keeps its own bit-position counter and pins it to that pulse, so its view of the frame follows the sender. Incoming bits move through a serial-to-parallel shifter.

When the final bit of a timeslot lands, the assembled byte is copied into a holding register together with its slot index, and a one-clock valid strobe is raised. The holding register then keeps the byte steady for the whole of the next timeslot, so downstream logic has eight clocks to use it. Code substitution is not undone: payload bytes come out exactly as they were received. Clock recovery and searching for a sync pattern belong to other blocks.

Top module: `tdm_frame_deserializer`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has rx_valid = 0, rx_byte = 0 and rx_slot = 0.
- R2: After reset, rx_valid stays low until the first cycle in which sync_in is high.
- R3: A cycle with sync_in high makes the bit sampled in that cycle bit position 0 of the frame. This applies even in the middle of a frame, and the block realigns to it at once.
- R4: Bits arrive most significant first: the first bit of a timeslot becomes rx_byte[7], and the eighth bit becomes rx_byte[0].
- R5: rx_valid is high for exactly one clock, in the cycle after the last bit of a timeslot was sampled. A full frame yields one pulse for each of the 32 timeslots.
- R6: While rx_valid is high, rx_slot gives the index of the timeslot the byte came from. This is the frame position divided by 8, so it runs from 0 to 31.
- R7: rx_byte and rx_slot do not change in any cycle in which rx_valid is low.
- R8: A frame is 256 bit times. Without a new sync, bit position 255 is followed by position 0, and slot 31 by slot 0.
- R9: A received byte of 00000010 is delivered unchanged, like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| sync_in | input | 1 | High during the first bit of a frame |
| rx_byte | output | 8 | Held byte of the most recently completed timeslot |
| rx_slot | output | 5 | Timeslot index of rx_byte |
| rx_valid | output | 1 | One-clock strobe when rx_byte and rx_slot update |

## Verification
The bench builds the block with its default 8-bit slots and 32 slots per frame. At that size one frame is 256 clocks, so counter wraparound from slot 31 to slot 0 can be reached in a short run, and every slot index can be checked in a single frame. A bench-side serializer feeds frames generated from a table of seeds. Directed runs then cover a frame without sync, a sync arriving part-way through a frame, and a reset during traffic.

// File: rtl/tdm_rx_pkg.sv
// Package: shared types for the TDM receive path.
// Assumes: nothing beyond IEEE 1800-2017.
package tdm_rx_pkg;

    // Alignment state of the receive counter
    typedef enum logic {
        RX_FREE   = 1'b0,
        RX_LOCKED = 1'b1
    } rx_align_e;

    // True when a value is a nonzero power of two
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/tdm_rx_counter.sv
// Module: bit-position counter for the receive frame.
// Tracks which bit of the frame is sampled this cycle. A high sync_in forces
// the current position to zero. Flags the last bit of each slot once aligned.
// Assumes: SLOT_BITS and NUM_SLOTS are powers of two, so the counter wraps
// at the frame length on its own.
module tdm_rx_counter #(
    parameter int POS_W = 8,
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic [POS_W-1:0] pos,
    output logic             locked,
    output logic             slot_end
);
    import tdm_rx_pkg::*;

    logic [POS_W-1:0] cnt_q;
    rx_align_e        align_q;
    logic             lock_now;

    // Position of the bit sampled this cycle, with sync taking priority
    always_comb begin
        pos = sync_in ? '0 : cnt_q;
    end

    // Alignment is in force from the sync cycle onward
    always_comb begin
        lock_now = (align_q == RX_LOCKED) || sync_in;
        locked   = (align_q == RX_LOCKED);
        slot_end = lock_now && (pos[BIT_W-1:0] == {BIT_W{1'b1}});
    end

    // Advance the counter; it wraps at the frame length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= pos + POS_W'(1);
        end
    end

    // Latch alignment on the first sync after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_q <= RX_FREE;
        end else if (sync_in) begin
            align_q <= RX_LOCKED;
        end
    end

    // R3
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (cnt_q == POS_W'(1)));

    // R8
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_in && cnt_q == {POS_W{1'b1}}) |=> (cnt_q == '0));

endmodule

// File: rtl/tdm_rx_shift.sv
// Module: serial-in parallel-out shifter.
// Shifts one bit per clock in at the low end, so the earliest bit ends up
// in the most significant position. It also presents the word as it will
// be after this cycle's bit.
// Assumes: W >= 2.
module tdm_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [W-1:0] word_now
);
    logic [W-1:0] sr_q;

    // Word including the bit sampled this cycle
    always_comb begin
        word_now = {sr_q[W-2:0], ser_in};
    end

    // Shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= word_now;
        end
    end

    // R4
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q[0] == $past(ser_in)));

endmodule

// File: rtl/tdm_rx_hold.sv
// Module: holding register for a completed byte and its slot index.
// Loads on the slot-end flag and raises valid for the following clock.
// Assumes: load is never high in two consecutive cycles.
module tdm_rx_hold #(
    parameter int W  = 8,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  word_in,
    input  logic [SW-1:0] slot_in,
    output logic [W-1:0]  data_q,
    output logic [SW-1:0] slot_q,
    output logic          valid_q
);
    // Capture byte and slot at the slot boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            slot_q <= '0;
        end else if (load) begin
            data_q <= word_in;
            slot_q <= slot_in;
        end
    end

    // One-clock strobe following each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> ($stable(data_q) && $stable(slot_q)));

endmodule

// File: rtl/tdm_frame_deserializer.sv
// Module: TDM frame deserializer, top level.
// Aligns a frame counter to sync_in, assembles each slot's byte MSB first,
// and presents it with its slot index in a holding register for one slot.
// Assumes: SLOT_BITS and NUM_SLOTS are powers of two; one bit per clock.
module tdm_frame_deserializer #(
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_in,
    input  logic                         sync_in,
    output logic [SLOT_BITS-1:0]         rx_byte,
    output logic [$clog2(NUM_SLOTS)-1:0] rx_slot,
    output logic                         rx_valid
);
    localparam int BIT_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int POS_W  = BIT_W + SLOT_W;

    logic [POS_W-1:0]     pos;
    logic                 locked;
    logic                 slot_end;
    logic [SLOT_BITS-1:0] word_now;

    tdm_rx_counter #(.POS_W(POS_W), .BIT_W(BIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .pos      (pos),
        .locked   (locked),
        .slot_end (slot_end)
    );

    tdm_rx_shift #(.W(SLOT_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .word_now (word_now)
    );

    tdm_rx_hold #(.W(SLOT_BITS), .SW(SLOT_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slot_end),
        .word_in (word_now),
        .slot_in (pos[POS_W-1:BIT_W]),
        .data_q  (rx_byte),
        .slot_q  (rx_slot),
        .valid_q (rx_valid)
    );

    // R2
    no_valid_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(locked) || $past(sync_in)));

    // R6
    slot_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_slot == $past(pos[POS_W-1:BIT_W])));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && rx_byte == '0 && rx_slot == '0));

endmodule

// File: tb/sim_tdm_frame_deserializer.sv
`timescale 1ns/1ps
module sim_tdm_frame_deserializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       sync_in = 1'b0;
    logic [7:0] rx_byte;
    logic [4:0] rx_slot;
    logic       rx_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] recv [32];
    bit         got  [32];
    int         nvalid = 0;
    bit         prev_v = 1'b0;
    logic [7:0] last_byte = '0;
    logic [4:0] last_slot = '0;

    // Frame seeds: {seed, step}; slot k carries seed + k*step except fixed slots
    localparam logic [15:0] VEC [4] = '{16'h1003, 16'hA511, 16'h00FF, 16'h7E2D};

    always #2.5 clk = ~clk;

    tdm_frame_deserializer u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_in(sync_in),
        .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected payload: slots 5,6,7 fixed to 02 (R9), 80 and 01 (R4)
    function automatic logic [7:0] exp_byte(input logic [7:0] seed, input logic [7:0] step, input int k);
        if (k == 5) return 8'h02;
        if (k == 6) return 8'h80;
        if (k == 7) return 8'h01;
        return seed + 8'(k) * step;
    endfunction

    // Output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v = 1'b0;
            last_byte = '0;
            last_slot = '0;
        end else begin
            if (rx_valid) begin
                recv[rx_slot] = rx_byte;
                got[rx_slot] = 1'b1;
                nvalid++;
                // R5 single-cycle strobe
                chk(!prev_v, "R5 valid longer than one clock", 1, 0);
            end else begin
                // R7 held outputs
                chk(rx_byte == last_byte && rx_slot == last_slot, "R7 hold changed",
                    {rx_slot, rx_byte}, {last_slot, last_byte});
            end
            prev_v = rx_valid;
            last_byte = rx_byte;
            last_slot = rx_slot;
        end
    end

    task automatic clear_rx();
        for (int k = 0; k < 32; k++) begin got[k] = 1'b0; recv[k] = '0; end
        nvalid = 0;
    endtask

    task automatic send_frame(input logic [7:0] seed, input logic [7:0] step, input bit with_sync);
        for (int k = 0; k < 32; k++) begin
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                sync_in = with_sync && (k == 0) && (b == 7);
                ser_in  = exp_byte(seed, step, k)[b];
            end
        end
    endtask

    task automatic compare(input logic [7:0] seed, input logic [7:0] step, input int exp_n, input string tag);
        @(negedge clk);
        sync_in = 1'b0; ser_in = 1'b0;
        #1;
        for (int k = 0; k < 32; k++) begin
            chk(got[k] && recv[k] == exp_byte(seed, step, k), tag, recv[k], exp_byte(seed, step, k));
        end
        chk(nvalid == exp_n, "R5 pulse count per frame", nvalid, exp_n);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!rx_valid && rx_byte == 0 && rx_slot == 0, "R1 reset outputs", {rx_valid, rx_slot, rx_byte}, 0);
        rst_n = 1'b1;

        // R2 no strobe before the first sync
        clear_rx();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            ser_in = 1'(i % 3);
        end
        @(negedge clk); #1;
        chk(nvalid == 0, "R2 valid before sync", nvalid, 0);

        // Table walk: R4, R6, R9 over several payload patterns
        for (int i = 0; i < 4; i++) begin
            clear_rx();
            send_frame(VEC[i][15:8], VEC[i][7:0], 1'b1);
            compare(VEC[i][15:8], VEC[i][7:0], 32, "R4 R6 R9 slot payload");
        end

        // R8 wrap: second frame carries no sync
        clear_rx();
        send_frame(8'h33, 8'h07, 1'b1);
        send_frame(8'hC1, 8'h0B, 1'b0);
        compare(8'hC1, 8'h0B, 64, "R8 wrap payload");

        // R3 sync part-way through a frame realigns at once
        @(negedge clk); sync_in = 1'b1; ser_in = 1'b1;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk); sync_in = 1'b0; ser_in = 1'b1;
        end
        clear_rx();
        send_frame(8'h5A, 8'h13, 1'b1);
        compare(8'h5A, 8'h13, 32, "R3 resync payload");

        // R1 mid-traffic reset, then R2 again
        @(negedge clk); rst_n = 1'b0; ser_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!rx_valid && rx_byte == 0 && rx_slot == 0, "R1 reset in traffic", {rx_valid, rx_slot, rx_byte}, 0);
        rst_n = 1'b1;
        clear_rx();
        repeat (20) @(negedge clk);
        #1;
        chk(nvalid == 0, "R2 valid after reset without sync", nvalid, 0);
        clear_rx();
        send_frame(8'hE0, 8'h21, 1'b1);
        compare(8'hE0, 8'h21, 32, "R6 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule